// File: doc/BRIEF.md
# Accumulator Logical Left Shifter with Status Flags

This unit is the execution slice of a small DSP-style datapath that carries out one instruction: a logical left shift of the 32-bit accumulator. The shift distance comes from a 16-bit temporary register. Vacated low bits are filled with zeros. Each time the shift runs, the carry, zero and negative status flags are rewritten from the result.

The unit watches an instruction-valid strobe and a 16-bit instruction word. When the word matches the shift opcode, it registers the shifted accumulator, the three flags and a cleared repeat count on the next rising clock edge. The shift cannot be repeated. If a repeat prefix has left a nonzero count, the count is dropped and the shift happens once. A one-cycle squash indication tells the sequencer that this happened. In any cycle without a matching instruction, the registered results keep their values.

Top module: `acc_shl_unit`

## Requirements
- R1: The shift distance is `tmp_in[4:0]` (0 to 31). Bits `tmp_in[15:5]` have no effect on any output.
- R2: On execution, `acc_out` becomes `acc_in` shifted left by the distance, with zeros entering at bit 0 and bits past bit 31 discarded.
- R3: On execution with a nonzero distance n, `flag_c` becomes `acc_in[32-n]`. With a zero distance, `flag_c` becomes 0 and `acc_out` equals `acc_in`.
- R4: On execution, `flag_z` becomes 1 exactly when the new `acc_out` is zero. This includes a zero-distance shift.
- R5: On execution, `flag_n` becomes bit 31 of the new `acc_out`. This includes a zero-distance shift.
- R6: On execution, `rpt_out` becomes 0 whatever `rpt_in` holds. `rpt_squash` is 1 for that one cycle exactly when `rpt_in` was nonzero, and the update is applied once.
- R7: Execution happens only when `instr_valid` is 1 and `instr_word` equals 16'h563B. Results appear on the outputs one clock edge later.
- R8: In a cycle without execution, `acc_out`, `flag_c`, `flag_z`, `flag_n` and `rpt_out` keep their values, and `rpt_squash` returns to 0.
- R9: A synchronous active-high `rst` clears `acc_out`, all three flags, `rpt_out` and `rpt_squash` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Instruction word to decode |
| acc_in | input | 32 | Current accumulator value |
| tmp_in | input | 16 | Temporary register; low five bits give the shift distance |
| rpt_in | input | 16 | Pending repeat count |
| acc_out | output | 32 | Registered shifted accumulator |
| flag_c | output | 1 | Carry: last bit shifted out, or 0 for a zero distance |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |
| rpt_out | output | 16 | Registered repeat count, cleared by execution |
| rpt_squash | output | 1 | One-cycle pulse: a nonzero repeat count was dropped |

## Verification
Two things can happen in the same cycle. One is cancelling a pending repeat count. The other is the shift itself, with its flag update, including the zero-distance case where carry is cleared but zero and negative are still evaluated. The bench provokes this overlap by issuing the opcode while `rpt_in` is nonzero, both at random and in directed cases where the distance is 0 or 31, or the result shifts out to zero. It then checks the accumulator, all three flags, the cleared count and the squash pulse together against a bench model. Separate cycles use near-miss opcodes and a deasserted strobe to show that nothing moves.

// File: rtl/acc_shl_pkg.sv
package acc_shl_pkg;

    parameter int unsigned ACC_W_DEF = 32;
    parameter int unsigned TMP_W_DEF = 16;
    parameter int unsigned RPT_W_DEF = 16;
    parameter int unsigned OPC_W_DEF = 16;
    parameter logic [15:0] OPC_SHL_DEF = 16'h563B;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
    } stat_flags_t;

endpackage

// File: rtl/acc_shl_decode.sv
module acc_shl_decode #(
    parameter int unsigned OPC_W = 16,
    parameter logic [OPC_W-1:0] OPC_SHL = '0
) (
    input  logic             instr_valid,
    input  logic [OPC_W-1:0] instr_word,
    output logic             fire
);
    always_comb begin
        fire = instr_valid && (instr_word == OPC_SHL);
    end
endmodule

// File: rtl/acc_shl_barrel.sv
module acc_shl_barrel #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 5
) (
    input  logic [W-1:0]  val,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  res,
    output logic          carry
);
    // One extra bit on top catches the last bit pushed out; it starts at zero,
    // so a zero distance yields a cleared carry without a separate mux.
    logic [W:0] stg [CW+1];

    assign stg[0] = {1'b0, val};

    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int unsigned SH = 2 ** k;
        assign stg[k+1] = cnt[k] ? (stg[k] << SH) : stg[k];
    end

    assign res   = stg[CW][W-1:0];
    assign carry = stg[CW][W];
endmodule

// File: rtl/acc_shl_flags.sv
module acc_shl_flags #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] res,
    output logic         is_zero,
    output logic         is_neg
);
    always_comb begin
        is_zero = ~|res;
        is_neg  = res[W-1];
    end
endmodule

// File: rtl/acc_shl_unit.sv
module acc_shl_unit
    import acc_shl_pkg::*;
#(
    parameter int unsigned ACC_W = ACC_W_DEF,
    parameter int unsigned TMP_W = TMP_W_DEF,
    parameter int unsigned RPT_W = RPT_W_DEF,
    parameter int unsigned OPC_W = OPC_W_DEF,
    parameter logic [OPC_W-1:0] OPC_SHL = OPC_SHL_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [OPC_W-1:0] instr_word,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [TMP_W-1:0] tmp_in,
    input  logic [RPT_W-1:0] rpt_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             flag_c,
    output logic             flag_z,
    output logic             flag_n,
    output logic [RPT_W-1:0] rpt_out,
    output logic             rpt_squash
);
    localparam int unsigned CNT_W = $clog2(ACC_W);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        stat_flags_t      fl;
        logic [RPT_W-1:0] rpt;
        logic             sq;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic             fire;
    logic [CNT_W-1:0] sh_cnt;
    logic [ACC_W-1:0] sh_res;
    logic             sh_carry;
    logic             res_zero;
    logic             res_neg;
    logic             unused_tmp_hi;

    assign sh_cnt        = tmp_in[CNT_W-1:0];
    assign unused_tmp_hi = ^tmp_in[TMP_W-1:CNT_W];

    acc_shl_decode #(
        .OPC_W   (OPC_W),
        .OPC_SHL (OPC_SHL)
    ) u_dec (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .fire        (fire)
    );

    acc_shl_barrel #(
        .W  (ACC_W),
        .CW (CNT_W)
    ) u_sh (
        .val   (acc_in),
        .cnt   (sh_cnt),
        .res   (sh_res),
        .carry (sh_carry)
    );

    acc_shl_flags #(
        .W (ACC_W)
    ) u_fl (
        .res     (sh_res),
        .is_zero (res_zero),
        .is_neg  (res_neg)
    );

    always_comb begin
        st_d    = st_q;
        st_d.sq = 1'b0;
        if (fire) begin
            st_d.acc  = sh_res;
            st_d.fl.c = sh_carry;
            st_d.fl.z = res_zero;
            st_d.fl.n = res_neg;
            st_d.rpt  = '0;
            st_d.sq   = |rpt_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out    = st_q.acc;
    assign flag_c     = st_q.fl.c;
    assign flag_z     = st_q.fl.z;
    assign flag_n     = st_q.fl.n;
    assign rpt_out    = st_q.rpt;
    assign rpt_squash = st_q.sq;
endmodule

// File: rtl/acc_shl_chk.sv
module acc_shl_chk #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned TMP_W = 16,
    parameter int unsigned RPT_W = 16,
    parameter int unsigned OPC_W = 16,
    parameter logic [OPC_W-1:0] OPC_SHL = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_valid,
    input logic [OPC_W-1:0] instr_word,
    input logic [ACC_W-1:0] acc_in,
    input logic [TMP_W-1:0] tmp_in,
    input logic [RPT_W-1:0] rpt_in,
    input logic [ACC_W-1:0] acc_out,
    input logic             flag_c,
    input logic             flag_z,
    input logic             flag_n,
    input logic [RPT_W-1:0] rpt_out,
    input logic             rpt_squash
);
    localparam int unsigned CNT_W = $clog2(ACC_W);

    logic go;
    assign go = instr_valid && (instr_word == OPC_SHL);

    AST_ZERO_DIST: assert property (@(posedge clk) disable iff (rst)
        (go && tmp_in[CNT_W-1:0] == '0) |=> (acc_out == $past(acc_in) && !flag_c)); // R3
    AST_ZFLAG: assert property (@(posedge clk) disable iff (rst)
        go |=> (flag_z == (acc_out == '0))); // R4
    AST_NFLAG: assert property (@(posedge clk) disable iff (rst)
        go |=> (flag_n == acc_out[ACC_W-1])); // R5
    AST_RPT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        go |=> (rpt_out == '0 && rpt_squash == ($past(rpt_in) != '0))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !go |=> ($stable(acc_out) && $stable(flag_c) && $stable(flag_z) && $stable(flag_n)
                 && $stable(rpt_out) && !rpt_squash)); // R8
    AST_RESET_CLR: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !flag_c && !flag_z && !flag_n && rpt_out == '0 && !rpt_squash)); // R9
endmodule

bind acc_shl_unit acc_shl_chk #(
    .ACC_W   (ACC_W),
    .TMP_W   (TMP_W),
    .RPT_W   (RPT_W),
    .OPC_W   (OPC_W),
    .OPC_SHL (OPC_SHL)
) u_chk (.*);

// File: tb/tb_acc_shl_unit.sv
module tb_acc_shl_unit;

    localparam logic [15:0] OPC = 16'h563B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [31:0] acc_in = '0;
    logic [15:0] tmp_in = '0;
    logic [15:0] rpt_in = '0;
    logic [31:0] acc_out;
    logic        flag_c, flag_z, flag_n;
    logic [15:0] rpt_out;
    logic        rpt_squash;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [31:0] m_acc = '0;
    logic        m_c = 1'b0, m_z = 1'b0, m_n = 1'b0, m_sq = 1'b0;
    logic [15:0] m_rpt = '0;

    always #5 clk = ~clk;

    acc_shl_unit dut (
        .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr_word (instr_word),
        .acc_in (acc_in), .tmp_in (tmp_in), .rpt_in (rpt_in),
        .acc_out (acc_out), .flag_c (flag_c), .flag_z (flag_z), .flag_n (flag_n),
        .rpt_out (rpt_out), .rpt_squash (rpt_squash)
    );

    function automatic logic [31:0] exp_res(input logic [31:0] a, input logic [15:0] t);
        return a << t[4:0];
    endfunction

    function automatic logic exp_carry(input logic [31:0] a, input logic [15:0] t);
        int n;
        n = int'(t[4:0]);
        return (n == 0) ? 1'b0 : a[32-n];
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input bit fired);
        if (fired) begin
            cmp("R2", "acc_out", acc_out, m_acc);
            cmp("R3", "flag_c", 32'(flag_c), 32'(m_c));
            cmp("R4", "flag_z", 32'(flag_z), 32'(m_z));
            cmp("R5", "flag_n", 32'(flag_n), 32'(m_n));
            cmp("R6", "rpt_out", 32'(rpt_out), 32'(m_rpt));
            cmp("R6", "rpt_squash", 32'(rpt_squash), 32'(m_sq));
        end else begin
            cmp("R8", "acc_out", acc_out, m_acc);
            cmp("R8", "flags", {29'd0, flag_c, flag_z, flag_n}, {29'd0, m_c, m_z, m_n});
            cmp("R8", "rpt_out", 32'(rpt_out), 32'(m_rpt));
            cmp("R8", "rpt_squash", 32'(rpt_squash), 32'(m_sq));
        end
    endtask

    // R7: execution only with strobe and exact opcode, visible after one edge
    task automatic step(input logic v, input logic [15:0] w, input logic [31:0] a,
                        input logic [15:0] t, input logic [15:0] r);
        bit fired;
        @(negedge clk);
        instr_valid = v; instr_word = w; acc_in = a; tmp_in = t; rpt_in = r;
        @(posedge clk);
        #1;
        fired = v && (w == OPC);
        if (fired) begin
            m_acc = exp_res(a, t);
            m_c   = exp_carry(a, t);
            m_z   = (m_acc == 32'd0);
            m_n   = m_acc[31];
            m_rpt = 16'd0;
            m_sq  = (r != 16'd0);
        end else begin
            m_sq = 1'b0;
        end
        check_all(fired);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_acc = '0; m_c = 0; m_z = 0; m_n = 0; m_rpt = '0; m_sq = 0;
        cmp("R9", "acc_out", acc_out, 32'd0);
        cmp("R9", "flags+sq", {28'd0, flag_c, flag_z, flag_n, rpt_squash}, 32'd0);
        cmp("R9", "rpt_out", 32'(rpt_out), 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1D5C_0A77));
        repeat (2) @(posedge clk);
        do_reset();

        // R3 zero distance, acc unchanged, carry cleared, N/Z still evaluated
        step(1, OPC, 32'h8000_0001, 16'h0000, 16'h0000);
        // R1 upper temp bits ignored: distance is 0
        step(1, OPC, 32'h0000_0000, 16'hFFE0, 16'h0003);
        // R3 distance 31: carry from bit 1
        step(1, OPC, 32'h0000_0003, 16'h001F, 16'h0000);
        // R1 upper bits set with distance 1; carry from bit 31
        step(1, OPC, 32'hC000_0000, 16'hA5E1, 16'h0010);
        // R4 shift out to zero
        step(1, OPC, 32'h0000_F000, 16'h0014, 16'hFFFF);
        // R7 near-miss opcode and strobe low: R8 hold
        step(1, 16'h563A, 32'hFFFF_FFFF, 16'h0004, 16'h0007);
        step(0, OPC, 32'h1234_5678, 16'h0008, 16'h0001);
        // R6 squash pulse then drops
        step(1, OPC, 32'h0F0F_0F0F, 16'h0004, 16'h0002);
        step(0, 16'h0000, 32'h0, 16'h0, 16'h0);

        for (int i = 0; i < 400; i++) begin
            logic        v;
            logic [15:0] w;
            logic [31:0] a;
            v = ($urandom % 8) != 0;
            case ($urandom % 4)
                0: w = 16'($urandom);
                1: w = OPC ^ (16'd1 << ($urandom % 16));
                default: w = OPC;
            endcase
            case ($urandom % 5)
                0: a = 32'd0;
                1: a = 32'h8000_0000 >> ($urandom % 32);
                default: a = $urandom;
            endcase
            step(v, w, a, 16'($urandom), (($urandom % 2) != 0) ? 16'($urandom) : 16'd0);
            if (i == 200) do_reset();
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule